// File: doc/BRIEF.md
# Configuration Bit Command Controller

This block keeps the non-volatile configuration state of an embedded flash. It holds three registers: a word of general-purpose configuration bits, a word of per-region lock bits, and one security bit. A host drives it over a parallel programming port. Every exchange on that port is a request/ready handshake. The host raises `req_i`, with `wr_i` giving the direction. The controller answers with a one-cycle `rdy_o` pulse. The host must then drop `req_i` before the controller will accept its next handshake.

A command begins with a write handshake that carries a command word. Bits [15:12] of that word hold the mode field, and bits [7:0] hold the command code. The command then continues according to its kind:
- A set or clear command takes a second write handshake with the mask.
- A read command takes a read handshake that returns the data word.
- An erase-all command keeps the controller busy for a fixed number of cycles and then wipes the configuration bits.

Once the security bit is set, every command is refused. Only the hardware erase input clears the security bit, and only while the flash reports itself erased.

Top module: `nvm_cfg_ctrl`

## Requirements
- R1: During and after reset, the configuration word equals POR_CFG (default 16'h0001), the lock word equals POR_LOCK (default 16'h00F0) and security equals POR_SEC (default 0). rdy_o, busy_o and err_o are 0.
- R2: Each accepted handshake produces a single one-cycle rdy_o pulse. A request held high after its ready is not accepted a second time. A command word counts as valid only when bits [15:12] equal 4'hA.
- R3: Set-configuration (code 8'h21) followed by a mask write ORs the mask into the configuration word. Mask bit n controls bit n.
- R4: Clear-configuration (code 8'h22) followed by a pattern write clears each configuration bit whose pattern bit is 1. The other bits keep their value.
- R5: Read-configuration (code 8'h23) followed by a read handshake returns the configuration word on rdata_o. Bit n is 1 when configuration bit n is active.
- R6: Set-lock (8'h31) and clear-lock (8'h32) update the lock word with mask semantics. Read-lock (8'h33) returns it, with bit n at 1 when lock bit n is set.
- R7: Erase-all (code 8'h40) holds busy_o high for exactly ERASE_CYCLES cycles (default 8), counting from the ready cycle. The configuration word is cleared when busy_o falls. The lock word and the security bit are unchanged.
- R8: A command word with an unknown code or a wrong mode field sets err_o and changes no register. The next accepted valid command clears err_o.
- R9: Set-security (code 8'h50) makes secure_o 1. While secure_o is 1, every command word is acknowledged but refused: err_o goes to 1, no register changes and busy_o stays 0.
- R10: secure_o is cleared only by a cycle with erase_pin_i high while flash_erased_i is high. A pulse on erase_pin_i while flash_erased_i is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Handshake request, held until ready |
| wr_i | input | 1 | 1 for a write handshake, 0 for a read handshake |
| wdata_i | input | 16 | Command word or mask argument |
| rdy_o | output | 1 | One-cycle ready pulse ending a handshake |
| rdata_o | output | 16 | Data word returned by a read handshake |
| busy_o | output | 1 | High while an erase-all is running |
| err_o | output | 1 | Last command was unknown or refused |
| flash_erased_i | input | 1 | Flash array reports itself erased |
| erase_pin_i | input | 1 | Hardware erase event |
| cfg_o | output | 16 | Configuration bits |
| lock_o | output | 16 | Lock bits |
| secure_o | output | 1 | Security bit |

## Verification
Every result is registered at the clock edge that accepts a handshake. rdy_o, rdata_o, err_o, secure_o and a set or clear to cfg_o or lock_o therefore become visible in the cycle right after that edge. The bench drives on falling edges and samples on falling edges. It polls for the rdy_o pulse and reads the results no earlier than the falling edge where that pulse is seen. For erase-all, busy_o rises in the ready cycle, and the bench counts the falling edges at which busy_o is high, expecting exactly ERASE_CYCLES of them. It then checks cfg_o in the first cycle after busy_o drops.

// File: rtl/nvm_cfg_pkg.sv
package nvm_cfg_pkg;

  localparam logic [3:0] MODE_CMD    = 4'hA;
  localparam logic [7:0] CODE_SETCFG = 8'h21;
  localparam logic [7:0] CODE_CLRCFG = 8'h22;
  localparam logic [7:0] CODE_RDCFG  = 8'h23;
  localparam logic [7:0] CODE_SETLK  = 8'h31;
  localparam logic [7:0] CODE_CLRLK  = 8'h32;
  localparam logic [7:0] CODE_RDLK   = 8'h33;
  localparam logic [7:0] CODE_ERASE  = 8'h40;
  localparam logic [7:0] CODE_SETSEC = 8'h50;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARG,
    ST_RD,
    ST_ERASE
  } ctrl_st_e;

  typedef enum logic [3:0] {
    OP_BAD,
    OP_SET_CFG,
    OP_CLR_CFG,
    OP_RD_CFG,
    OP_SET_LK,
    OP_CLR_LK,
    OP_RD_LK,
    OP_ERASE,
    OP_SET_SEC
  } cmd_op_e;

endpackage

// File: rtl/nvm_cmd_decode.sv
module nvm_cmd_decode
  import nvm_cfg_pkg::*;
(
  input  logic [3:0] mode_i,
  input  logic [7:0] code_i,
  output cmd_op_e    op_o
);

  always_comb begin
    op_o = OP_BAD;
    if (mode_i == MODE_CMD) begin
      unique case (code_i)
        CODE_SETCFG: op_o = OP_SET_CFG;
        CODE_CLRCFG: op_o = OP_CLR_CFG;
        CODE_RDCFG:  op_o = OP_RD_CFG;
        CODE_SETLK:  op_o = OP_SET_LK;
        CODE_CLRLK:  op_o = OP_CLR_LK;
        CODE_RDLK:   op_o = OP_RD_LK;
        CODE_ERASE:  op_o = OP_ERASE;
        CODE_SETSEC: op_o = OP_SET_SEC;
        default:     op_o = OP_BAD;
      endcase
    end
  end

endmodule

// File: rtl/nvm_hs_gate.sv
module nvm_hs_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic open_i,
  output logic take_o
);

  logic armed_q;
  logic armed_d;

  assign take_o = req_i && armed_q && open_i;

  always_comb begin
    armed_d = armed_q;
    if (take_o)      armed_d = 1'b0;
    else if (!req_i) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b1;
    else        armed_q <= armed_d;
  end

endmodule

// File: rtl/nvm_erase_timer.sv
module nvm_erase_timer #(
  parameter int ERASE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);

  localparam int CW = (ERASE_CYCLES > 1) ? $clog2(ERASE_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(ERASE_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          cnt_en;

  assign busy_o = run_q;
  assign done_o = run_q && (cnt_q == '0);
  assign cnt_en = start_i || run_q;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start_i) begin
      cnt_d = LOAD;
      run_d = 1'b1;
    end else if (done_o) begin
      run_d = 1'b0;
    end else if (run_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/nvm_bit_bank.sv
module nvm_bit_bank #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         wipe_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_d;
  logic         en;

  assign en = wipe_i || (|set_i) || (|clr_i);

  always_comb begin
    if (wipe_i) q_d = '0;
    else        q_d = (q_o | set_i) & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_o <= INIT;
    else if (en) q_o <= q_d;
  end

endmodule

// File: rtl/nvm_cfg_ctrl.sv
module nvm_cfg_ctrl
  import nvm_cfg_pkg::*;
#(
  parameter int              DW           = 16,
  parameter logic [DW-1:0]   POR_CFG      = 16'h0001,
  parameter logic [DW-1:0]   POR_LOCK     = 16'h00F0,
  parameter logic            POR_SEC      = 1'b0,
  parameter int              ERASE_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          rdy_o,
  output logic [DW-1:0] rdata_o,
  output logic          busy_o,
  output logic          err_o,
  input  logic          flash_erased_i,
  input  logic          erase_pin_i,
  output logic [DW-1:0] cfg_o,
  output logic [DW-1:0] lock_o,
  output logic          secure_o
);

  localparam int MODE_HI = DW - 1;
  localparam int MODE_LO = DW - 4;

  ctrl_st_e      st_q, st_d;
  cmd_op_e       pend_q, pend_d;
  cmd_op_e       op;
  logic          rdy_d, err_d, sec_d;
  logic [DW-1:0] rdata_d;
  logic          open, take, erase_start, erase_done;
  logic [DW-1:0] cfg_set, cfg_clr, lk_set, lk_clr;
  logic          cfg_wipe;

  nvm_cmd_decode u_dec (
    .mode_i (wdata_i[MODE_HI:MODE_LO]),
    .code_i (wdata_i[7:0]),
    .op_o   (op)
  );

  always_comb begin
    unique case (st_q)
      ST_IDLE, ST_ARG: open = wr_i;
      ST_RD:           open = !wr_i;
      default:         open = 1'b0;
    endcase
  end

  nvm_hs_gate u_hs (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .open_i (open),
    .take_o (take)
  );

  nvm_erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (erase_start),
    .busy_o  (busy_o),
    .done_o  (erase_done)
  );

  nvm_bit_bank #(.W(DW), .INIT(POR_CFG)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (cfg_set),
    .clr_i  (cfg_clr),
    .wipe_i (cfg_wipe),
    .q_o    (cfg_o)
  );

  nvm_bit_bank #(.W(DW), .INIT(POR_LOCK)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (lk_set),
    .clr_i  (lk_clr),
    .wipe_i (1'b0),
    .q_o    (lock_o)
  );

  // next-state process
  always_comb begin
    st_d        = st_q;
    pend_d      = pend_q;
    rdy_d       = 1'b0;
    err_d       = err_o;
    sec_d       = secure_o;
    rdata_d     = rdata_o;
    erase_start = 1'b0;
    cfg_set     = '0;
    cfg_clr     = '0;
    lk_set      = '0;
    lk_clr      = '0;
    cfg_wipe    = 1'b0;

    if (erase_pin_i && flash_erased_i) sec_d = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (take) begin
          rdy_d = 1'b1;
          if (secure_o || op == OP_BAD) begin
            err_d = 1'b1;
          end else begin
            err_d = 1'b0;
            unique case (op)
              OP_SET_SEC: sec_d = 1'b1;
              OP_ERASE: begin
                erase_start = 1'b1;
                st_d        = ST_ERASE;
              end
              OP_RD_CFG, OP_RD_LK: begin
                pend_d = op;
                st_d   = ST_RD;
              end
              default: begin
                pend_d = op;
                st_d   = ST_ARG;
              end
            endcase
          end
        end
      end
      ST_ARG: begin
        if (take) begin
          rdy_d = 1'b1;
          st_d  = ST_IDLE;
          unique case (pend_q)
            OP_SET_CFG: cfg_set = wdata_i;
            OP_CLR_CFG: cfg_clr = wdata_i;
            OP_SET_LK:  lk_set  = wdata_i;
            OP_CLR_LK:  lk_clr  = wdata_i;
            default:    ;
          endcase
        end
      end
      ST_RD: begin
        if (take) begin
          rdy_d   = 1'b1;
          st_d    = ST_IDLE;
          rdata_d = (pend_q == OP_RD_CFG) ? cfg_o : lock_o;
        end
      end
      default: begin
        if (erase_done) begin
          cfg_wipe = 1'b1;
          st_d     = ST_IDLE;
        end
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      pend_q   <= OP_BAD;
      rdy_o    <= 1'b0;
      err_o    <= 1'b0;
      secure_o <= POR_SEC;
      rdata_o  <= '0;
    end else begin
      st_q     <= st_d;
      pend_q   <= pend_d;
      rdy_o    <= rdy_d;
      err_o    <= err_d;
      secure_o <= sec_d;
      if (rdy_d) rdata_o <= rdata_d;
    end
  end

endmodule

// File: rtl/nvm_cfg_ctrl_chk.sv
module nvm_cfg_ctrl_chk #(
  parameter int DW           = 16,
  parameter int ERASE_CYCLES = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rdy_o,
  input logic          busy_o,
  input logic          err_o,
  input logic          secure_o,
  input logic          flash_erased_i,
  input logic          erase_pin_i,
  input logic [DW-1:0] cfg_o,
  input logic [DW-1:0] lock_o
);

  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= '0;
  end

  AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |=> !rdy_o); // R2

  AST_ERASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(busy_o)) |-> (run_q == ERASE_CYCLES)); // R7

  AST_ERASE_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(busy_o)) |-> (cfg_o == '0)); // R7

  AST_BUSY_NO_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> !rdy_o); // R7

  AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> ($stable(cfg_o) && $stable(lock_o))); // R8

  AST_SEC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    secure_o |=> ($stable(cfg_o) && $stable(lock_o))); // R9

  AST_SEC_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (secure_o && $past(secure_o)) |-> !$rose(busy_o)); // R9

  AST_SEC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(secure_o) |-> ($past(erase_pin_i) && $past(flash_erased_i))); // R10

endmodule

bind nvm_cfg_ctrl nvm_cfg_ctrl_chk #(.DW(DW), .ERASE_CYCLES(ERASE_CYCLES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rdy_o          (rdy_o),
  .busy_o         (busy_o),
  .err_o          (err_o),
  .secure_o       (secure_o),
  .flash_erased_i (flash_erased_i),
  .erase_pin_i    (erase_pin_i),
  .cfg_o          (cfg_o),
  .lock_o         (lock_o)
);

// File: tb/tb_nvm_cfg_ctrl.sv
module tb_nvm_cfg_ctrl;

  logic        clk;
  logic        rst_n;
  logic        req_i, wr_i;
  logic [15:0] wdata_i;
  logic        rdy_o, busy_o, err_o, secure_o;
  logic [15:0] rdata_o, cfg_o, lock_o;
  logic        flash_erased_i, erase_pin_i;

  int total = 0;
  int bad   = 0;
  bit fin   = 0;

  nvm_cfg_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .rdy_o(rdy_o), .rdata_o(rdata_o), .busy_o(busy_o), .err_o(err_o),
    .flash_erased_i(flash_erased_i), .erase_pin_i(erase_pin_i),
    .cfg_o(cfg_o), .lock_o(lock_o), .secure_o(secure_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {code, argument, expected configuration word}
  localparam logic [39:0] VEC [6] = '{
    {8'h21, 16'h00F0, 16'h00F1},
    {8'h22, 16'h0011, 16'h00E0},
    {8'h21, 16'h8000, 16'h80E0},
    {8'h22, 16'h0000, 16'h80E0},
    {8'h21, 16'hFFFF, 16'hFFFF},
    {8'h22, 16'h0F0F, 16'hF0F0}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic hs_write(input logic [15:0] d);
    int n;
    req_i = 1'b1; wr_i = 1'b1; wdata_i = d;
    n = 0;
    do begin @(negedge clk); n++; end while (!rdy_o && n < 50);
    if (!rdy_o) chk("R2 write ready", 16'(rdy_o), 16'h1);
    req_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic hs_read(output logic [15:0] d);
    int n;
    req_i = 1'b1; wr_i = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!rdy_o && n < 50);
    if (!rdy_o) chk("R2 read ready", 16'(rdy_o), 16'h1);
    d = rdata_o;
    req_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int          nrdy, nbusy;
    rst_n = 1'b0; req_i = 1'b0; wr_i = 1'b0; wdata_i = '0;
    flash_erased_i = 1'b0; erase_pin_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 cfg in reset", cfg_o, 16'h0001);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cfg", cfg_o, 16'h0001);
    chk("R1 lock", lock_o, 16'h00F0);
    chk("R1 secure/busy/err/rdy", {12'h0, secure_o, busy_o, err_o, rdy_o}, 16'h0);

    // table walk: R3 set, R4 clear, R5 read-back
    foreach (VEC[i]) begin
      hs_write({8'hA0, VEC[i][39:32]});
      hs_write(VEC[i][31:16]);
      chk((VEC[i][39:32] == 8'h21) ? "R3 set cfg" : "R4 clear cfg", cfg_o, VEC[i][15:0]);
      hs_write(16'hA023);
      hs_read(rd);
      chk("R5 read cfg", rd, VEC[i][15:0]);
    end

    // R6 lock bits
    hs_write(16'hA031); hs_write(16'h000F);
    chk("R6 set lock", lock_o, 16'h00FF);
    hs_write(16'hA032); hs_write(16'h00F0);
    chk("R6 clear lock", lock_o, 16'h000F);
    hs_write(16'hA033); hs_read(rd);
    chk("R6 read lock", rd, 16'h000F);

    // R2 request held high after ready: only one ready
    req_i = 1'b1; wr_i = 1'b1; wdata_i = 16'hA021;
    nrdy = 0;
    repeat (8) begin @(negedge clk); if (rdy_o) nrdy++; end
    req_i = 1'b0; @(negedge clk);
    chk("R2 single ready while held", 16'(nrdy), 16'd1);
    hs_write(16'h0001);
    chk("R2 argument after release", cfg_o, 16'hF0F1);

    // R8 unknown code and bad mode
    hs_write(16'hA077);
    chk("R8 unknown code err", 16'(err_o), 16'h1);
    chk("R8 unknown code cfg", cfg_o, 16'hF0F1);
    hs_write(16'h3021);
    hs_write(16'h0100);
    chk("R8 bad mode cfg", cfg_o, 16'hF0F1);
    chk("R8 bad mode lock", lock_o, 16'h000F);
    hs_write(16'hA023);
    chk("R8 err cleared", 16'(err_o), 16'h0);
    hs_read(rd);

    // R7 erase-all
    req_i = 1'b1; wr_i = 1'b1; wdata_i = 16'hA040;
    nrdy = 0;
    do begin @(negedge clk); nrdy++; end while (!rdy_o && nrdy < 50);
    req_i = 1'b0;
    nbusy = 0;
    while (busy_o && nbusy < 100) begin nbusy++; @(negedge clk); end
    chk("R7 busy length", 16'(nbusy), 16'd8);
    chk("R7 cfg wiped", cfg_o, 16'h0000);
    chk("R7 lock kept", lock_o, 16'h000F);
    chk("R7 secure kept", 16'(secure_o), 16'h0);

    // R9 security lockout
    hs_write(16'hA021); hs_write(16'h1234);
    hs_write(16'hA050);
    chk("R9 secure set", 16'(secure_o), 16'h1);
    hs_write(16'hA022);
    chk("R9 refused err", 16'(err_o), 16'h1);
    chk("R9 cfg frozen", cfg_o, 16'h1234);
    hs_write(16'hA040);
    chk("R9 erase refused", 16'(busy_o), 16'h0);
    chk("R9 cfg still frozen", cfg_o, 16'h1234);

    // R10 erase pin
    erase_pin_i = 1'b1; @(negedge clk); erase_pin_i = 1'b0; @(negedge clk);
    chk("R10 pin without erased flash", 16'(secure_o), 16'h1);
    flash_erased_i = 1'b1;
    erase_pin_i = 1'b1; @(negedge clk); erase_pin_i = 1'b0; @(negedge clk);
    chk("R10 pin with erased flash", 16'(secure_o), 16'h0);
    hs_write(16'hA021); hs_write(16'h0008);
    chk("R10 commands work again", cfg_o, 16'h123C);
    chk("R10 err clear", 16'(err_o), 16'h0);

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule